// File: doc/BRIEF.md
# Segmented Page Translator with Direct-Mapped TLB

This block turns a 32-bit effective address into a real address once a block-level translation has already missed. The top four address bits pick one of sixteen segment registers. The selected register supplies a 24-bit virtual segment identifier, two protection keys (one for supervisor state and one for problem state), a no-execute flag and an unsupported-format flag. The 16-bit page index and the segment identifier are then compared against one slot of a 64-entry direct-mapped page TLB. The slot is chosen by the low six bits of the page index.

On a TLB hit, the protection key chosen by the requester's privilege state and the two protection bits of the page entry decide whether the access is allowed. When it is allowed, the real address is the stored 20-bit real page number followed by the 12-bit byte offset. Each fault is reported with its own cause code. Software loads the segment registers through a write port and loads TLB slots through a fill port. A separate input wipes all TLB valid bits at once. Walking an in-memory page table on a miss is left to the surrounding logic.

Top module: `seg_page_xlate`

## Requirements
- R1: After reset, rsp_valid, rsp_hit, rsp_ra and rsp_fault are all zero, every TLB slot is invalid and every segment register reads as zero. A lookup therefore reports a miss (fault code 1).
- R2: Each cycle with req_valid high produces exactly one response on the next cycle, with rsp_valid high. No response appears without a request.
- R3: The segment register is selected by req_ea[31:28]. In sr_wr_data, counting bit 0 as the most significant bit (bit 31), the fields are: bit 0 unsupported flag, bit 1 supervisor key, bit 2 problem-state key, bit 3 no-execute, bits 8..31 (sr_wr_data[23:0]) the segment identifier.
- R4: If the selected segment's unsupported flag is set, the fault is 3 (unsupported), whatever the TLB contents or the access type.
- R5: A fetch (req_acc=2) through a segment with no-execute set faults with 2 (protection), even when the TLB would miss. Reads and writes through the same segment proceed normally.
- R6: A hit requires the indexed slot to be valid, its segment identifier to equal the segment's, and its full 16-bit page index to equal req_ea[27:12]. Otherwise the fault is 1 (miss).
- R7: The TLB slot is pidx[5:0], where pidx is req_ea[27:12] for lookups and fill_pidx for fills. A fill overwrites the valid bit, segment identifier, page index, real page number and protection bits of that slot, so two pages sharing an index evict each other.
- R8: On an allowed hit, rsp_hit=1, rsp_fault=0 and rsp_ra = {real page number, req_ea[11:0]}. On any fault, rsp_hit=0 and rsp_ra=0.
- R9: The key in force is the problem-state key when req_pr=1 and the supervisor key when req_pr=0.
- R10: With key 0, reads (req_acc=0) and fetches are allowed for every protection value, and writes (req_acc=1) are allowed unless pp=3. A denial is fault 2.
- R11: With key 1, pp=0 denies every access, pp=1 and pp=3 allow reads and fetches but deny writes, and pp=2 allows everything.
- R12: inval_all clears every valid bit in one cycle. A fill in the same cycle still installs its slot.
- R13: A segment write or TLB fill takes effect for requests in the following cycle. A request in the same cycle sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_wr_en | input | 1 | Segment register write strobe |
| sr_wr_idx | input | 4 | Segment register number to write |
| sr_wr_data | input | 32 | Segment register value (layout in R3) |
| fill_en | input | 1 | TLB fill strobe |
| fill_vsid | input | 24 | Segment identifier for the filled slot |
| fill_pidx | input | 16 | Page index of the filled page (low 6 bits pick the slot) |
| fill_rpn | input | 20 | Real page number |
| fill_pp | input | 2 | Page protection bits |
| inval_all | input | 1 | Clear every TLB valid bit |
| req_valid | input | 1 | Lookup request strobe |
| req_ea | input | 32 | Effective address |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 fetch, 3 treated as read |
| req_pr | input | 1 | Problem (user) state |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | Allowed translation |
| rsp_ra | output | 32 | Real address |
| rsp_fault | output | 2 | 0 none, 1 miss, 2 protection, 3 unsupported segment |

## Verification
The bench sweeps all three access types in both privilege states over pages with each of the four protection values. This separates a wrong key choice from a wrong matrix row. Lookups with a mismatched segment identifier, and with an aliasing page index that shares a slot, tell a full-tag compare apart from an index-only or identifier-only compare. They also show fills evicting. Fetches through a no-execute segment that both hits and misses in the TLB pin down the fault priority, as does a segment with the unsupported flag set. Requests issued in the same cycle as a segment write, a fill, or an invalidate together with a fill separate old-versus-new visibility and fill-over-invalidate ordering.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_MISS  = 2'd1,
    FLT_PROT  = 2'd2,
    FLT_UNSUP = 2'd3
  } flt_e;

  // Segment word fields, counted from the most significant bit (bit 0 = MSB)
  localparam int SRF_UNSUP = 0;
  localparam int SRF_KSUP  = 1;
  localparam int SRF_KUSR  = 2;
  localparam int SRF_NOEX  = 3;

endpackage

// File: rtl/seg_file.sv
module seg_file #(
  parameter int SEG_CNT = 16,
  parameter int WORD_W  = 32,
  parameter int VSID_W  = 24,
  localparam int SEL_W  = $clog2(SEG_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_idx,
  output logic              rd_unsup,
  output logic              rd_ksup,
  output logic              rd_kusr,
  output logic              rd_noex,
  output logic [VSID_W-1:0] rd_vsid
);
  import seg_xlate_pkg::*;

  // decoded write fields
  logic              w_unsup, w_ksup, w_kusr, w_noex;
  logic [VSID_W-1:0] w_vsid;
  logic              unused_fmt_bits;

  assign w_unsup = wr_data[WORD_W-1-SRF_UNSUP];
  assign w_ksup  = wr_data[WORD_W-1-SRF_KSUP];
  assign w_kusr  = wr_data[WORD_W-1-SRF_KUSR];
  assign w_noex  = wr_data[WORD_W-1-SRF_NOEX];
  assign w_vsid  = wr_data[VSID_W-1:0];
  assign unused_fmt_bits = ^wr_data[WORD_W-5:VSID_W];

  logic [SEG_CNT-1:0] unsup_v, ksup_v, kusr_v, noex_v;
  logic [VSID_W-1:0]  vsid_a [SEG_CNT];

  for (genvar g = 0; g < SEG_CNT; g++) begin : g_seg
    logic              we;
    logic              unsup_q, ksup_q, kusr_q, noex_q;
    logic [VSID_W-1:0] vsid_q;

    always_comb begin
      we = wr_en && (wr_idx == g[SEL_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        unsup_q <= 1'b0;
        ksup_q  <= 1'b0;
        kusr_q  <= 1'b0;
        noex_q  <= 1'b0;
        vsid_q  <= '0;
      end else if (we) begin
        unsup_q <= w_unsup;
        ksup_q  <= w_ksup;
        kusr_q  <= w_kusr;
        noex_q  <= w_noex;
        vsid_q  <= w_vsid;
      end
    end

    assign unsup_v[g] = unsup_q;
    assign ksup_v[g]  = ksup_q;
    assign kusr_v[g]  = kusr_q;
    assign noex_v[g]  = noex_q;
    assign vsid_a[g]  = vsid_q;
  end

  assign rd_unsup = unsup_v[rd_idx];
  assign rd_ksup  = ksup_v[rd_idx];
  assign rd_kusr  = kusr_v[rd_idx];
  assign rd_noex  = noex_v[rd_idx];
  assign rd_vsid  = vsid_a[rd_idx];

endmodule

// File: rtl/page_tlb.sv
module page_tlb #(
  parameter int DEPTH  = 64,
  parameter int VSID_W = 24,
  parameter int PIDX_W = 16,
  parameter int RPN_W  = 20,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inval_all,
  input  logic              fill_en,
  input  logic [VSID_W-1:0] fill_vsid,
  input  logic [PIDX_W-1:0] fill_pidx,
  input  logic [RPN_W-1:0]  fill_rpn,
  input  logic [1:0]        fill_pp,
  input  logic [VSID_W-1:0] look_vsid,
  input  logic [PIDX_W-1:0] look_pidx,
  output logic              hit,
  output logic [RPN_W-1:0]  hit_rpn,
  output logic [1:0]        hit_pp
);

  logic [IDX_W-1:0] fill_idx, look_idx;
  assign fill_idx = fill_pidx[IDX_W-1:0];
  assign look_idx = look_pidx[IDX_W-1:0];

  logic [DEPTH-1:0]  valid_v;
  logic [VSID_W-1:0] tag_vsid [DEPTH];
  logic [PIDX_W-1:0] tag_pidx [DEPTH];
  logic [RPN_W-1:0]  slot_rpn [DEPTH];
  logic [1:0]        slot_pp  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic              we;
    logic              v_d, v_q;
    logic [VSID_W-1:0] vsid_q;
    logic [PIDX_W-1:0] pidx_q;
    logic [RPN_W-1:0]  rpn_q;
    logic [1:0]        pp_q;

    // fill into this slot wins over a same-cycle wipe
    always_comb begin
      we = fill_en && (fill_idx == g[IDX_W-1:0]);
      if (we)             v_d = 1'b1;
      else if (inval_all) v_d = 1'b0;
      else                v_d = v_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_d;
    end

    always_ff @(posedge clk) begin
      if (we) begin
        vsid_q <= fill_vsid;
        pidx_q <= fill_pidx;
        rpn_q  <= fill_rpn;
        pp_q   <= fill_pp;
      end
    end

    assign valid_v[g]  = v_q;
    assign tag_vsid[g] = vsid_q;
    assign tag_pidx[g] = pidx_q;
    assign slot_rpn[g] = rpn_q;
    assign slot_pp[g]  = pp_q;
  end

  assign hit     = valid_v[look_idx]
                && (tag_vsid[look_idx] == look_vsid)
                && (tag_pidx[look_idx] == look_pidx);
  assign hit_rpn = slot_rpn[look_idx];
  assign hit_pp  = slot_pp[look_idx];

endmodule

// File: rtl/perm_check.sv
module perm_check (
  input  logic       key,
  input  logic [1:0] pp,
  input  logic [1:0] acc,
  output logic       allow
);
  import seg_xlate_pkg::*;

  logic is_wr;
  assign is_wr = (acc == ACC_WRITE);

  always_comb begin
    if (!key) begin
      allow = !(is_wr && (pp == 2'b11));
    end else begin
      case (pp)
        2'b00:   allow = 1'b0;
        2'b10:   allow = 1'b1;
        default: allow = !is_wr;
      endcase
    end
  end

endmodule

// File: rtl/seg_page_xlate.sv
module seg_page_xlate #(
  parameter int EA_W      = 32,
  parameter int OFF_W     = 12,
  parameter int SEG_CNT   = 16,
  parameter int TLB_DEPTH = 64,
  parameter int VSID_W    = 24,
  localparam int SEL_W    = $clog2(SEG_CNT),
  localparam int PIDX_W   = EA_W - SEL_W - OFF_W,
  localparam int RPN_W    = EA_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sr_wr_en,
  input  logic [SEL_W-1:0]  sr_wr_idx,
  input  logic [EA_W-1:0]   sr_wr_data,
  input  logic              fill_en,
  input  logic [VSID_W-1:0] fill_vsid,
  input  logic [PIDX_W-1:0] fill_pidx,
  input  logic [RPN_W-1:0]  fill_rpn,
  input  logic [1:0]        fill_pp,
  input  logic              inval_all,
  input  logic              req_valid,
  input  logic [EA_W-1:0]   req_ea,
  input  logic [1:0]        req_acc,
  input  logic              req_pr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [EA_W-1:0]   rsp_ra,
  output logic [1:0]        rsp_fault
);
  import seg_xlate_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  // address split
  logic [SEL_W-1:0]  ea_sel;
  logic [PIDX_W-1:0] ea_pidx;
  logic [OFF_W-1:0]  ea_off;
  assign ea_sel  = req_ea[EA_W-1 -: SEL_W];
  assign ea_pidx = req_ea[OFF_W +: PIDX_W];
  assign ea_off  = req_ea[OFF_W-1:0];

  logic              seg_unsup, seg_ksup, seg_kusr, seg_noex;
  logic [VSID_W-1:0] seg_vsid;

  seg_file #(
    .SEG_CNT (SEG_CNT),
    .WORD_W  (EA_W),
    .VSID_W  (VSID_W)
  ) u_seg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (sr_wr_en),
    .wr_idx   (sr_wr_idx),
    .wr_data  (sr_wr_data),
    .rd_idx   (ea_sel),
    .rd_unsup (seg_unsup),
    .rd_ksup  (seg_ksup),
    .rd_kusr  (seg_kusr),
    .rd_noex  (seg_noex),
    .rd_vsid  (seg_vsid)
  );

  logic             tlb_hit;
  logic [RPN_W-1:0] tlb_rpn;
  logic [1:0]       tlb_pp;

  page_tlb #(
    .DEPTH  (TLB_DEPTH),
    .VSID_W (VSID_W),
    .PIDX_W (PIDX_W),
    .RPN_W  (RPN_W)
  ) u_tlb (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .inval_all (inval_all),
    .fill_en   (fill_en),
    .fill_vsid (fill_vsid),
    .fill_pidx (fill_pidx),
    .fill_rpn  (fill_rpn),
    .fill_pp   (fill_pp),
    .look_vsid (seg_vsid),
    .look_pidx (ea_pidx),
    .hit       (tlb_hit),
    .hit_rpn   (tlb_rpn),
    .hit_pp    (tlb_pp)
  );

  logic key_sel, pp_allow;
  assign key_sel = req_pr ? seg_kusr : seg_ksup;

  perm_check u_perm (
    .key   (key_sel),
    .pp    (tlb_pp),
    .acc   (req_acc),
    .allow (pp_allow)
  );

  // next-state
  flt_e            cause;
  logic            valid_d, hit_d;
  logic [EA_W-1:0] ra_d;
  logic [1:0]      fault_d;

  always_comb begin
    if (seg_unsup)                               cause = FLT_UNSUP;
    else if (seg_noex && (req_acc == ACC_FETCH)) cause = FLT_PROT;
    else if (!tlb_hit)                           cause = FLT_MISS;
    else if (!pp_allow)                          cause = FLT_PROT;
    else                                         cause = FLT_NONE;

    valid_d = req_valid;
    hit_d   = req_valid && (cause == FLT_NONE);
    ra_d    = hit_d ? {tlb_rpn, ea_off} : '0;
    fault_d = req_valid ? cause : FLT_NONE;
  end

  // response registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_ra    <= '0;
      rsp_fault <= '0;
    end else if (req_valid || rsp_valid) begin
      rsp_valid <= valid_d;
      rsp_hit   <= hit_d;
      rsp_ra    <= ra_d;
      rsp_fault <= fault_d;
    end
  end

endmodule

// File: rtl/seg_page_xlate_checker.sv
module seg_page_xlate_checker #(
  parameter int OFF_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [OFF_W-1:0] req_off,
  input logic             inval_all,
  input logic             fill_en,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [OFF_W-1:0] rsp_off,
  input logic [1:0]       rsp_fault
);

  p_one_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_hit_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_valid && rsp_fault == 2'd0));

  p_offset_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!rsp_hit || rsp_off == $past(req_off)));

  p_wipe_misses_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $past(inval_all) && !$past(fill_en)) |=> !rsp_hit);

endmodule

bind seg_page_xlate seg_page_xlate_checker #(.OFF_W(OFF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .req_off   (req_ea[OFF_W-1:0]),
  .inval_all (inval_all),
  .fill_en   (fill_en),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_off   (rsp_ra[OFF_W-1:0]),
  .rsp_fault (rsp_fault)
);

// File: tb/seg_page_xlate_bench.sv
`timescale 1ns/1ps
module seg_page_xlate_bench;

  logic        clk;
  logic        rst_n;
  logic        sr_wr_en;
  logic [3:0]  sr_wr_idx;
  logic [31:0] sr_wr_data;
  logic        fill_en;
  logic [23:0] fill_vsid;
  logic [15:0] fill_pidx;
  logic [19:0] fill_rpn;
  logic [1:0]  fill_pp;
  logic        inval_all;
  logic        req_valid;
  logic [31:0] req_ea;
  logic [1:0]  req_acc;
  logic        req_pr;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [31:0] rsp_ra;
  logic [1:0]  rsp_fault;

  seg_page_xlate u_seg_page_xlate (
    .clk(clk), .rst_n(rst_n),
    .sr_wr_en(sr_wr_en), .sr_wr_idx(sr_wr_idx), .sr_wr_data(sr_wr_data),
    .fill_en(fill_en), .fill_vsid(fill_vsid), .fill_pidx(fill_pidx),
    .fill_rpn(fill_rpn), .fill_pp(fill_pp), .inval_all(inval_all),
    .req_valid(req_valid), .req_ea(req_ea), .req_acc(req_acc), .req_pr(req_pr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ra(rsp_ra), .rsp_fault(rsp_fault)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic        hit;
    logic [31:0] ra;
    logic [1:0]  flt;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  // reference state kept from the requirements
  logic [31:0] m_sr   [16];
  logic        m_v    [64];
  logic [23:0] m_vsid [64];
  logic [15:0] m_pidx [64];
  logic [19:0] m_rpn  [64];
  logic [1:0]  m_pp   [64];

  function automatic logic [31:0] mk_sr(logic u, logic ks, logic kp, logic nx, logic [23:0] vs);
    return {u, ks, kp, nx, 4'b0000, vs};
  endfunction

  function automatic exp_t predict(logic [31:0] ea, logic [1:0] acc, logic pr, string tag);
    exp_t e;
    logic [31:0] s;
    logic [5:0]  ix;
    logic        found, key, ok;
    s  = m_sr[ea[31:28]];
    ix = ea[17:12];
    found = m_v[ix] && (m_vsid[ix] == s[23:0]) && (m_pidx[ix] == ea[27:12]);
    key = pr ? s[29] : s[30];
    if (acc == 2'd1) ok = key ? (m_pp[ix] == 2'd2) : (m_pp[ix] != 2'd3);
    else             ok = !(key && m_pp[ix] == 2'd0);
    e.tag = tag;
    e.hit = 1'b0;
    e.ra  = 32'h0;
    if (s[31])                         e.flt = 2'd3;
    else if (s[28] && acc == 2'd2)     e.flt = 2'd2;
    else if (!found)                   e.flt = 2'd1;
    else if (!ok)                      e.flt = 2'd2;
    else begin
      e.flt = 2'd0;
      e.hit = 1'b1;
      e.ra  = {m_rpn[ix], ea[11:0]};
    end
    return e;
  endfunction

  // one driven cycle; called at a falling edge
  task automatic drive(
    input logic do_sr, input logic [3:0] si, input logic [31:0] sd,
    input logic do_fill, input logic [23:0] fv, input logic [15:0] fp,
    input logic [19:0] fr, input logic [1:0] fpp,
    input logic do_inv,
    input logic do_req, input logic [31:0] ea, input logic [1:0] acc, input logic pr,
    input string tag);
    if (do_req) sb_q.push_back(predict(ea, acc, pr, tag));
    sr_wr_en = do_sr;  sr_wr_idx = si; sr_wr_data = sd;
    fill_en = do_fill; fill_vsid = fv; fill_pidx = fp; fill_rpn = fr; fill_pp = fpp;
    inval_all = do_inv;
    req_valid = do_req; req_ea = ea; req_acc = acc; req_pr = pr;
    if (do_sr) m_sr[si] = sd;
    if (do_inv) for (int i = 0; i < 64; i++) m_v[i] = 1'b0;
    if (do_fill) begin
      m_v[fp[5:0]] = 1'b1; m_vsid[fp[5:0]] = fv; m_pidx[fp[5:0]] = fp;
      m_rpn[fp[5:0]] = fr; m_pp[fp[5:0]] = fpp;
    end
    @(negedge clk);
    sr_wr_en = 1'b0; fill_en = 1'b0; inval_all = 1'b0; req_valid = 1'b0;
  endtask

  task automatic sr_wr(input logic [3:0] si, input logic [31:0] sd);
    drive(1, si, sd, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic fill(input logic [23:0] fv, input logic [15:0] fp, input logic [19:0] fr, input logic [1:0] fpp);
    drive(0, 0, 0, 1, fv, fp, fr, fpp, 0, 0, 0, 0, 0, "");
  endtask

  task automatic look(input logic [31:0] ea, input logic [1:0] acc, input logic pr, input string tag);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, ea, acc, pr, tag);
  endtask

  // monitor: compares each response with the oldest expectation
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R2: unexpected response hit=%0b fault=%0d, expected none", rsp_hit, rsp_fault);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (rsp_hit !== e.hit || rsp_ra !== e.ra || rsp_fault !== e.flt) begin
          errors++;
          $display("FAIL %s: got hit=%0b ra=%h fault=%0d, expected hit=%0b ra=%h fault=%0d",
                   e.tag, rsp_hit, rsp_ra, rsp_fault, e.hit, e.ra, e.flt);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_sr[i] = '0;
    for (int i = 0; i < 64; i++) begin
      m_v[i] = 0; m_vsid[i] = 0; m_pidx[i] = 0; m_rpn[i] = 0; m_pp[i] = 0;
    end
    rst_n = 1'b0;
    sr_wr_en = 0; sr_wr_idx = 0; sr_wr_data = 0;
    fill_en = 0; fill_vsid = 0; fill_pidx = 0; fill_rpn = 0; fill_pp = 0;
    inval_all = 0; req_valid = 0; req_ea = 0; req_acc = 0; req_pr = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_ra !== 32'h0 || rsp_fault !== 2'd0) begin
      errors++;
      $display("FAIL R1: reset outputs v=%0b h=%0b ra=%h f=%0d, expected all zero",
               rsp_valid, rsp_hit, rsp_ra, rsp_fault);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    look(32'h3123_4567, 2'd0, 0, "R1 empty tlb miss");

    // main page: key0 sup, key1 user, pp=3
    sr_wr(4'd3, mk_sr(0, 0, 1, 0, 24'hABCDE1));
    fill(24'hABCDE1, 16'h1234, 20'h89ABC, 2'd3);
    look(32'h3123_4567, 2'd0, 0, "R8 read hit real address");
    look(32'h3123_4567, 2'd1, 0, "R10 key0 pp3 write denied");
    look(32'h3123_4567, 2'd2, 0, "R10 key0 pp3 fetch allowed");
    look(32'h3123_4567, 2'd0, 1, "R9 problem key read pp3");
    look(32'h3123_4567, 2'd1, 1, "R11 key1 pp3 write denied");
    look(32'h4123_4567, 2'd0, 0, "R3 other segment vsid mismatch");
    look(32'h3563_4567, 2'd0, 0, "R6 alias page index miss");

    // eviction by alias
    fill(24'hABCDE1, 16'h5634, 20'h11111, 2'd2);
    look(32'h3563_4ABC, 2'd0, 0, "R7 alias fill hit");
    look(32'h3123_4567, 2'd0, 0, "R7 evicted page misses");
    look(32'h3563_4000, 2'd1, 1, "R11 key1 pp2 write allowed");

    // pp0 and pp1
    fill(24'hABCDE1, 16'h0001, 20'h22222, 2'd0);
    look(32'h3000_1010, 2'd0, 1, "R11 key1 pp0 read denied");
    look(32'h3000_1010, 2'd2, 1, "R11 key1 pp0 fetch denied");
    look(32'h3000_1010, 2'd1, 0, "R10 key0 pp0 write allowed");
    fill(24'hABCDE1, 16'h0002, 20'h33333, 2'd1);
    look(32'h3000_2FFC, 2'd1, 1, "R11 key1 pp1 write denied");
    look(32'h3000_2FFC, 2'd2, 1, "R11 key1 pp1 fetch allowed");
    look(32'h3000_2FFC, 2'd1, 0, "R10 key0 pp1 write allowed");

    // no-execute segment
    sr_wr(4'd5, mk_sr(0, 0, 0, 1, 24'h000055));
    fill(24'h000055, 16'h0003, 20'h44444, 2'd2);
    look(32'h5000_3008, 2'd2, 0, "R5 no-execute fetch on hit");
    look(32'h5000_3008, 2'd0, 0, "R5 read through no-execute segment");
    look(32'h5000_9000, 2'd2, 0, "R5 no-execute fetch beats miss");

    // unsupported segment
    sr_wr(4'd6, mk_sr(1, 0, 0, 0, 24'h000001));
    look(32'h6000_0000, 2'd0, 0, "R4 unsupported flag read");
    look(32'h6000_0000, 2'd2, 1, "R4 unsupported flag fetch");

    // same-cycle visibility
    drive(1, 4'd3, mk_sr(0, 0, 0, 0, 24'h000777), 0, 0, 0, 0, 0, 0,
          1, 32'h3563_4ABC, 2'd0, 0, "R13 request sees old segment");
    look(32'h3563_4ABC, 2'd0, 0, "R13 new segment next cycle");
    drive(0, 0, 0, 1, 24'h000777, 16'h0005, 20'h55555, 2'd2, 0,
          1, 32'h3000_5123, 2'd0, 0, "R13 request sees slot before fill");
    look(32'h3000_5123, 2'd0, 0, "R13 filled slot next cycle");

    // invalidate
    fill(24'h000777, 16'h0006, 20'h66666, 2'd2);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "");
    look(32'h3000_5123, 2'd0, 0, "R12 wiped slot misses");
    look(32'h3000_6123, 2'd0, 0, "R12 second wiped slot misses");
    fill(24'h000777, 16'h0005, 20'h55555, 2'd2);
    drive(0, 0, 0, 1, 24'h000777, 16'h0006, 20'h77777, 2'd2, 1, 0, 0, 0, 0, "");
    look(32'h3000_6123, 2'd0, 0, "R12 fill beats wipe");
    look(32'h3000_5123, 2'd0, 0, "R12 other slot wiped");

    repeat (3) @(negedge clk);
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R2: %0d responses missing, expected 0", sb_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule